// File: doc/BRIEF.md
# Wired-to-Message Interrupt Generator Node

This block gathers up to 128 wired interrupt lines from peripherals and converts each one into a single write message aimed at a fixed doorbell address of a downstream interrupt translator. Each pin has a programmable trigger type, a device identifier and an event identifier. Both identifiers travel in the message payload. Wide peripherals can span several nodes, and several narrow peripherals can share one node. Nodes are placed at consecutive 4 KiB register windows.

Software sets up the node through a simple register port. After a pin has raised a message, that pin stays in service and cannot raise another message until software writes its clear bit. A rising edge that arrives while the pin is in service is remembered. A level that is still high when the pin is cleared causes a new message. Among the pins ready to send, a round-robin arbiter picks one message at a time. The chosen message is held on a valid/ready master port until the receiver accepts it.

Top module: `msg_irq_node`

## Requirements
- R1: After reset no message is offered (`msg_valid_o` low), and every type and vector register reads as zero.
- R2: Trigger-type words sit at byte offset 4*(p/32) from 0x000, with pin p at bit p%32. A 1 selects active-high level trigger and a 0 selects rising-edge trigger. The words read back as written.
- R3: The vector word of pin p sits at 0x200 + 4*p. Bits [21:12] hold a 10-bit event identifier and bits [11:0] hold a 12-bit device identifier. On readback, bits [31:22] read as zero.
- R4: A rising edge on an edge-type pin that is idle produces a message within a few cycles. The message address is the `DOORBELL_ADDR` parameter. The data bits [21:10] carry the pin's device identifier and bits [9:0] carry its event identifier.
- R5: An offered message keeps its data and valid stable until `msg_ready_i` is seen. Exactly one handshake completes per message, after which valid drops.
- R6: A pin that has sent a message raises no further message until a 1 is written to its bit in the clear words. Clear word w is at 0xA00 + 4*w, with pin p at bit p%32. Bits written as 0 have no effect.
- R7: Rising edges on a pin that is in service are kept as one pending event and merge into it. Exactly one message is delivered after the clear.
- R8: If a level-type pin's input is still high when the pin is cleared, a new message follows. If the input is low at the clear, no message follows.
- R9: When several pins are ready together, they are served one message at a time in ascending pin order. The search starts just after the most recently served pin and wraps around at the top.
- R10: Reads of unmapped or misaligned offsets return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_PINS | Wired interrupt inputs, synchronous to clk_i |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte offset inside the node window |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational during a read strobe |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Message accepted by the receiver |
| msg_addr_o | output | ADDR_W | Doorbell address of the message |
| msg_data_o | output | 22 | {device id, event id} |

## Verification
The main path is driven with four input patterns:
- A single clean edge checks payload mapping and how long the message is held.
- A re-edge while the pin is in service, with and without a matching clear bit, checks that service blocks new messages and that zero bits in a clear write do nothing.
- A burst of edges before the clear checks that edges merge into one pending event instead of queueing.
- A level input that is high at one clear and low at the next checks that the level is sampled again after a clear.

Three pins firing in the same cycle, after a known last-served pin, check that the rotation order wraps.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;
  localparam int REG_AW = 12;
  localparam int DEV_W  = 12;
  localparam int EV_W   = 10;
  localparam int MSG_W  = DEV_W + EV_W;

  localparam logic [REG_AW-1:0] TYPE_BASE = 12'h000;
  localparam logic [REG_AW-1:0] VEC_BASE  = 12'h200;
  localparam logic [REG_AW-1:0] CLR_BASE  = 12'hA00;

  typedef struct packed {
    logic [DEV_W-1:0] dev;
    logic [EV_W-1:0]  ev;
  } vec_t;
endpackage

// File: rtl/msg_irq_regs.sv
module msg_irq_regs
  import msg_irq_pkg::*;
#(
  parameter int NUM_PINS = 128
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [REG_AW-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output logic [NUM_PINS-1:0]   level_o,
  output vec_t                  vec_o [NUM_PINS],
  output logic [NUM_PINS-1:0]   clr_o
);
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [NUM_PINS-1:0] level_q;
  vec_t                vec_q [NUM_PINS];
  logic                aligned, is_type, is_vec, is_clr;
  logic [REG_AW-3:0]   widx;
  logic [REG_AW-1:0]   voff;
  logic [PIN_W-1:0]    vidx;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign widx    = addr_i[REG_AW-1:2];
  assign voff    = addr_i - VEC_BASE;
  assign vidx    = voff[PIN_W+1:2];
  assign is_type = aligned && (addr_i < TYPE_BASE + REG_AW'(4*NUM_WORDS));
  assign is_vec  = aligned && (addr_i >= VEC_BASE) && (addr_i < VEC_BASE + REG_AW'(4*NUM_PINS));
  assign is_clr  = aligned && (addr_i >= CLR_BASE) && (addr_i < CLR_BASE + REG_AW'(4*NUM_WORDS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      for (int p = 0; p < NUM_PINS; p++) vec_q[p] <= '0;
    end else if (req_i && we_i) begin
      if (is_type)
        for (int p = 0; p < NUM_PINS; p++)
          if (widx == (REG_AW-2)'(p/32)) level_q[p] <= wdata_i[p%32];
      if (is_vec)
        vec_q[vidx] <= '{dev: wdata_i[DEV_W-1:0], ev: wdata_i[DEV_W+EV_W-1:DEV_W]};
    end
  end

  // write-one-to-clear strobes
  always_comb begin
    clr_o = '0;
    if (req_i && we_i && is_clr)
      for (int p = 0; p < NUM_PINS; p++)
        if (widx == (REG_AW-2)'(p/32 + CLR_BASE/4)) clr_o[p] = wdata_i[p%32];
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (is_type)
        for (int p = 0; p < NUM_PINS; p++)
          if (widx == (REG_AW-2)'(p/32)) rdata_o[p%32] = level_q[p];
      if (is_vec)
        rdata_o[DEV_W+EV_W-1:0] = {vec_q[vidx].ev, vec_q[vidx].dev};
    end
  end

  assign level_o = level_q;
  assign vec_o   = vec_q;
endmodule

// File: rtl/msg_irq_pins.sv
module msg_irq_pins #(
  parameter int NUM_PINS = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] clr_i,
  input  logic [NUM_PINS-1:0] grant_i,
  output logic [NUM_PINS-1:0] pend_o,
  output logic [NUM_PINS-1:0] svc_o,
  output logic [NUM_PINS-1:0] req_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic irq_q, pend_q, svc_q, set;

    // level: re-sample only when idle; edge: latch any rise, merging
    assign set = level_i[p] ? (irq_i[p] & ~svc_q & ~pend_q)
                            : (irq_i[p] & ~irq_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_q  <= 1'b0;
        pend_q <= 1'b0;
        svc_q  <= 1'b0;
      end else begin
        irq_q  <= irq_i[p];
        pend_q <= set | (pend_q & ~grant_i[p]);
        svc_q  <= (svc_q & ~clr_i[p]) | grant_i[p];
      end
    end

    assign pend_o[p] = pend_q;
    assign svc_o[p]  = svc_q;
    assign req_o[p]  = pend_q & ~svc_q;
  end
endmodule

// File: rtl/msg_irq_arb.sv
module msg_irq_arb #(
  parameter int NUM_PINS = 128,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [NUM_PINS-1:0] req_i,
  output logic [NUM_PINS-1:0] grant_o,
  output logic [PIN_W-1:0]    idx_o
);
  logic [PIN_W-1:0]    ptr_q;
  logic [NUM_PINS-1:0] upper, sel;
  logic                any;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) upper[i] = req_i[i] && (i >= int'(ptr_q));
    sel = (|upper) ? upper : req_i;
    idx_o = '0;
    for (int i = NUM_PINS-1; i >= 0; i--)
      if (sel[i]) idx_o = PIN_W'(i);
  end

  assign any     = |req_i;
  assign grant_o = (en_i && any) ? (NUM_PINS'(1) << idx_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ptr_q <= '0;
    else if (en_i && any)    ptr_q <= (int'(idx_o) == NUM_PINS-1) ? '0 : idx_o + 1'b1;
  end
endmodule

// File: rtl/msg_irq_node.sv
module msg_irq_node
  import msg_irq_pkg::*;
#(
  parameter int                NUM_PINS      = 128,
  parameter int                ADDR_W        = 32,
  parameter logic [ADDR_W-1:0] DOORBELL_ADDR = 32'h0801_0040
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic                reg_req_i,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [ADDR_W-1:0]   msg_addr_o,
  output logic [MSG_W-1:0]    msg_data_o
);
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [NUM_PINS-1:0] level_w, clr_w, grant_w, pend_w, svc_w, req_w;
  vec_t                vec_w [NUM_PINS];
  logic [PIN_W-1:0]    idx_w;
  logic                valid_q;
  vec_t                msg_q;

  msg_irq_regs #(.NUM_PINS(NUM_PINS)) i_regs (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .level_o(level_w), .vec_o(vec_w), .clr_o(clr_w)
  );

  msg_irq_pins #(.NUM_PINS(NUM_PINS)) i_pins (
    .clk_i, .rst_ni, .irq_i,
    .level_i(level_w), .clr_i(clr_w), .grant_i(grant_w),
    .pend_o(pend_w), .svc_o(svc_w), .req_o(req_w)
  );

  msg_irq_arb #(.NUM_PINS(NUM_PINS)) i_arb (
    .clk_i, .rst_ni, .en_i(~valid_q), .req_i(req_w),
    .grant_o(grant_w), .idx_o(idx_w)
  );

  // snapshot vector at grant so later reprogramming cannot disturb it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else if (|grant_w) begin
      valid_q <= 1'b1;
      msg_q   <= vec_w[idx_w];
    end else if (valid_q && msg_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign msg_valid_o = valid_q;
  assign msg_addr_o  = DOORBELL_ADDR;
  assign msg_data_o  = msg_q;
endmodule

// File: rtl/msg_irq_node_chk.sv
module msg_irq_node_chk #(
  parameter int NUM_PINS = 128,
  parameter int MSG_W    = 22
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                msg_valid_o,
  input logic                msg_ready_i,
  input logic [MSG_W-1:0]    msg_data_o,
  input logic [NUM_PINS-1:0] grant_w,
  input logic [NUM_PINS-1:0] pend_w,
  input logic [NUM_PINS-1:0] svc_w
);
  AST_MSG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_data_o)); // R5
  AST_NO_GRANT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> grant_w == '0); // R5
  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_w)); // R9
  AST_GRANT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |grant_w |-> (grant_w & ~(pend_w & ~svc_w)) == '0); // R6
  AST_SVC_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |grant_w |=> (svc_w & $past(grant_w)) == $past(grant_w)); // R6
  AST_MSG_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |grant_w |=> msg_valid_o); // R4
endmodule

bind msg_irq_node msg_irq_node_chk #(.NUM_PINS(NUM_PINS), .MSG_W(msg_irq_pkg::MSG_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
  .msg_data_o(msg_data_o), .grant_w(grant_w), .pend_w(pend_w), .svc_w(svc_w)
);

// File: tb/test_msg_irq_node.sv
module test_msg_irq_node;
  localparam int          CLK_PERIOD = 10;
  localparam int          NPINS      = 128;
  localparam logic [31:0] DOORBELL   = 32'h0801_0040;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] irq = '0;
  logic             req = 1'b0, we = 1'b0, ready = 1'b0;
  logic [11:0]      addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic             valid;
  logic [31:0]      maddr;
  logic [21:0]      mdata;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_irq_node #(.NUM_PINS(NPINS), .ADDR_W(32), .DOORBELL_ADDR(DOORBELL)) i_msg_irq_node (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .msg_valid_o(valid), .msg_ready_i(ready), .msg_addr_o(maddr), .msg_data_o(mdata)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [11:0] dev_of(int p); return 12'(12'h100 + p); endfunction
  function automatic logic [9:0]  ev_of(int p);  return 10'(p*5 + 1);     endfunction
  function automatic logic [21:0] exp_msg(int p); return {dev_of(p), ev_of(p)}; endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic wait_msg(input int p, input string tag);
    bit seen = 0;
    for (int i = 0; i < 12 && !seen; i++) begin
      @(negedge clk);
      seen = valid;
    end
    check(seen, {tag, " valid"}, 32'(valid), 1);
    check(mdata == exp_msg(p), {tag, " data"}, 32'(mdata), 32'(exp_msg(p)));
    check(maddr == DOORBELL, {tag, " addr"}, maddr, DOORBELL);
  endtask

  task automatic take_msg(input string tag);
    @(negedge clk); ready = 1;
    @(negedge clk); ready = 0;
    check(valid == 1'b0, {tag, " valid drops after handshake"}, 32'(valid), 0);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (valid) seen = 1;
    end
    check(!seen, tag, 32'(seen), 0);
  endtask

  task automatic clr_pin(input int p);
    reg_wr(12'(12'hA00 + 4*(p/32)), 32'(1) << (p%32));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(valid == 1'b0, "R1 no message after reset", 32'(valid), 0);
    reg_rd(12'h004, d);
    check(d == 0, "R1 type word reset", d, 0);
    reg_rd(12'h200 + 12'd28, d);
    check(d == 0, "R1 vector reset", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    reg_wr(12'h004, 32'h8000_0002);   // pins 33 and 63 level
    reg_rd(12'h004, d);
    check(d == 32'h8000_0002, "R2 type readback", d, 32'h8000_0002);
    reg_rd(12'h000, d);
    check(d == 0, "R2 other type word untouched", d, 0);
    reg_wr(12'h200 + 12'd28, 32'hFFFF_FFFF);
    reg_rd(12'h200 + 12'd28, d);
    check(d == 32'h003F_FFFF, "R3 vector upper bits zero", d, 32'h003F_FFFF);
    foreach (irq[p]) reg_wr(12'(12'h200 + 4*p), {10'b0, ev_of(p), dev_of(p)});
    reg_rd(12'h200 + 12'(4*90), d);
    check(d == {10'b0, ev_of(90), dev_of(90)}, "R3 vector field layout", d, {10'b0, ev_of(90), dev_of(90)});
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    reg_wr(12'h010, 32'hFFFF_FFFF);
    reg_wr(12'h402, 32'hFFFF_FFFF);
    reg_wr(12'h400, 32'hFFFF_FFFF);
    reg_rd(12'h010, d);
    check(d == 0, "R10 unmapped read zero", d, 0);
    reg_rd(12'h000, d);
    check(d == 0, "R10 type word0 unchanged", d, 0);
    reg_rd(12'h004, d);
    check(d == 32'h8000_0002, "R10 type word1 unchanged", d, 32'h8000_0002);
    reg_rd(12'h200, d);
    check(d == {10'b0, ev_of(0), dev_of(0)}, "R10 vector0 unchanged", d, {10'b0, ev_of(0), dev_of(0)});
    reg_rd(12'h202, d);
    check(d == 0, "R10 misaligned read zero", d, 0);
  endtask

  task automatic t_edge_basic();
    logic [21:0] first;
    @(negedge clk); irq[7] = 1;
    wait_msg(7, "R4 edge message");
    first = mdata;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(valid && mdata == first, "R5 held until ready", 32'(mdata), 32'(first));
    end
    take_msg("R5");
    @(negedge clk); irq[7] = 0;
    @(negedge clk); irq[7] = 1;
    expect_quiet(10, "R6 blocked while in service");
    reg_wr(12'hA00, 32'hFFFF_FF7F);
    expect_quiet(10, "R6 zero clear bit has no effect");
    clr_pin(7);
    wait_msg(7, "R7 latched edge delivered after clear");
    take_msg("R7");
  endtask

  task automatic t_edge_merge();
    @(negedge clk); irq[7] = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); irq[7] = 1;
      @(negedge clk); irq[7] = 0;
    end
    clr_pin(7);
    wait_msg(7, "R7 merged edges one message");
    take_msg("R7");
    clr_pin(7);
    expect_quiet(10, "R7 no second message from merged edges");
  endtask

  task automatic t_level();
    @(negedge clk); irq[33] = 1;
    wait_msg(33, "R8 level message");
    take_msg("R8");
    expect_quiet(5, "R8 no repeat before clear");
    clr_pin(33);
    wait_msg(33, "R8 still high after clear re-fires");
    take_msg("R8");
    @(negedge clk); irq[33] = 0;
    clr_pin(33);
    expect_quiet(10, "R8 low at clear no message");
  endtask

  task automatic t_rr();
    @(negedge clk); irq[60] = 1;
    wait_msg(60, "R9 prime pointer");
    take_msg("R9");
    clr_pin(60);
    @(negedge clk); irq[60] = 0;
    @(negedge clk); irq[3] = 1; irq[60] = 1; irq[90] = 1;
    wait_msg(90, "R9 first after pointer");
    take_msg("R9");
    wait_msg(3, "R9 wrap to low pin");
    take_msg("R9");
    wait_msg(60, "R9 last pin");
    take_msg("R9");
    clr_pin(3); clr_pin(60); clr_pin(90);
    expect_quiet(10, "R9 nothing left");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_unmapped();
    t_edge_basic();
    t_edge_merge();
    t_level();
    t_rr();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule